// File: doc/BRIEF.md
# Backscatter Link Clock Divider

This block turns a measured calibration interval into the tag-to-reader link clock. It takes the number of system clock cycles counted across the reader's calibration symbol and a one-bit divide-ratio selector. The selector chooses either a divide-by-8 or a divide-by-64/3 relation between that count and the link period. The block computes an integer division ratio with shifts and one add. The fraction that the shift drops is not simply truncated: it is compared against a threshold that depends on the selector, and the ratio is rounded up when the fraction reaches that threshold. This bounds the relative frequency error even when the system clock is slow. Any result below the smallest usable ratio of 3 is raised to 3, and a flag is set.

A calculator state machine (`CALC_IDLE` → `CALC_MULT` → `CALC_ROUND` → `CALC_IDLE`) captures the operands on `start`, forms the scaled product, rounds and clamps it, and raises `ready`. A generator state machine (`GEN_IDLE` → `GEN_RUN`) stays idle with its output low until the first ratio is ready. It then divides the system clock by the ratio. Even ratios use a single counter. Odd ratios combine a rising-edge register with a falling-edge copy, so the high time is exactly half the period. A new ratio is adopted only when a period wraps, so a recalculation never shortens or stretches a pulse.

Top module: `blf_link_divider`

## Requirements
- R1: With `dr_hi`=0 (divide by 8), the integer part is `trcal_cnt >> 3` and the fraction is `trcal_cnt[2:0]`. The ratio is the integer part plus one when the fraction is 4 or more, and the integer part otherwise.
- R2: With `dr_hi`=1 (divide by 64/3), the product P = 3·`trcal_cnt` is formed. The integer part is P >> 6 and the fraction is P[5:0]. The ratio is the integer part plus one when the fraction is 27 or more, and the integer part otherwise.
- R3: A rounded result below 3 is output as 3 with `clamped`=1. Any other result gives `clamped`=0. The ratio presented while `ready`=1 is never below 3.
- R4: `ready` is low in the cycle after `start` is sampled. It is high, with the new `ratio` and `clamped`, after the second clock edge following that sample. `ratio` does not change while `ready` stays high.
- R5: While running, `link_clk` has a period of exactly `ratio` system clock cycles.
- R6: The high time of `link_clk` is exactly half its period, for odd ratios as well as even ones.
- R7: A new ratio takes effect only at a period boundary. Every observed period equals either the old or the new full period, and the old period never returns once the new one has appeared.
- R8: After reset, `ready`=0, `ratio`=0, `clamped`=0 and `link_clk`=0.
- R9: `link_clk` stays low until the first ratio becomes ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that begins a ratio calculation |
| trcal_cnt | input | CNT_W | Measured calibration length in system clock cycles |
| dr_hi | input | 1 | Divide-ratio select: 1 = 64/3, 0 = 8 |
| ratio | output | RATIO_W | Final rounded and clamped division ratio |
| ready | output | 1 | Ratio valid |
| clamped | output | 1 | Ratio was raised to the minimum of 3 |
| link_clk | output | 1 | Divided link clock, 50% duty cycle |

## Verification
A wrong rounding threshold or shift shows up as a `ratio` that is off by one within two cycles of the `start` sample. It is most visible at the fraction boundaries (27/64 and 4/8), which the vectors straddle on purpose. A broken odd-ratio path shows up within one link period as a high time that differs from half the period by half a system cycle. A ratio that is swapped mid-period shows up as a rise-to-rise interval that matches neither the old period nor the new one.

// File: rtl/blf_pkg.sv
package blf_pkg;
    typedef enum logic [1:0] {
        CALC_IDLE  = 2'd0,
        CALC_MULT  = 2'd1,
        CALC_ROUND = 2'd2
    } calc_state_t;

    typedef enum logic {
        GEN_IDLE = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_t;

    localparam int MIN_RATIO   = 3;
    localparam int FRAC_TH_D21 = 27; // out of 64
    localparam int FRAC_TH_D8  = 4;  // out of 8
endpackage

// File: rtl/blf_ratio_calc.sv
module blf_ratio_calc
    import blf_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int RATIO_W = CNT_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   trcal_cnt,
    input  logic               dr_hi,
    output logic [RATIO_W-1:0] ratio,
    output logic               ready,
    output logic               clamped
);
    localparam int PROD_W = CNT_W + 2;

    calc_state_t state_q, state_n;

    logic [CNT_W-1:0]  cnt_q;
    logic              dr_q;
    logic [PROD_W-1:0] prod_q;
    logic [PROD_W-1:0] int_part;
    logic              round_up;
    logic [PROD_W-1:0] rounded;
    logic              below_min;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CALC_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CALC_IDLE:  if (start) state_n = CALC_MULT;
            CALC_MULT:  state_n = start ? CALC_MULT : CALC_ROUND;
            CALC_ROUND: state_n = start ? CALC_MULT : CALC_IDLE;
            default:    state_n = CALC_IDLE;
        endcase
    end

    // rounding datapath: shift, then compare the dropped bits to a threshold
    always_comb begin
        if (dr_q) begin
            int_part = prod_q >> 6;
            round_up = (prod_q[5:0] >= 6'(FRAC_TH_D21));
        end else begin
            int_part = prod_q >> 3;
            round_up = (prod_q[2:0] >= 3'(FRAC_TH_D8));
        end
        rounded   = int_part + {{(PROD_W-1){1'b0}}, round_up};
        below_min = (rounded < PROD_W'(MIN_RATIO));
    end

    // outputs and operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            dr_q    <= 1'b0;
            prod_q  <= '0;
            ratio   <= '0;
            ready   <= 1'b0;
            clamped <= 1'b0;
        end else if (start) begin
            cnt_q <= trcal_cnt;
            dr_q  <= dr_hi;
            ready <= 1'b0;
        end else begin
            unique case (state_q)
                CALC_IDLE: ;
                CALC_MULT: begin
                    if (dr_q) prod_q <= {1'b0, cnt_q, 1'b0} + {2'b00, cnt_q};
                    else      prod_q <= {2'b00, cnt_q};
                end
                CALC_ROUND: begin
                    ratio   <= below_min ? RATIO_W'(MIN_RATIO) : rounded[RATIO_W-1:0];
                    clamped <= below_min;
                    ready   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready); // R4
    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(ratio)); // R4
    AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        clamped |-> (ratio == RATIO_W'(MIN_RATIO))); // R3
    AST_READY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ratio >= RATIO_W'(MIN_RATIO))); // R3
endmodule

// File: rtl/blf_clk_gen.sv
module blf_clk_gen
    import blf_pkg::*;
#(
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               ratio_vld,
    output logic               link_clk
);
    gen_state_t st_q, st_n;

    logic [RATIO_W-1:0] cnt_q, cnt_n;
    logic [RATIO_W-1:0] act_q, act_n;
    logic [RATIO_W-1:0] hi_n;
    logic               q_pos_n;
    logic               q_pos_q;
    logic               q_neg_q;
    logic               odd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GEN_IDLE;
        else        st_q <= st_n;
    end

    // next state, counter and ratio adoption at period wrap only
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        act_n = act_q;
        unique case (st_q)
            GEN_IDLE: begin
                if (ratio_vld) begin
                    st_n  = GEN_RUN;
                    cnt_n = '0;
                    act_n = ratio_in;
                end
            end
            GEN_RUN: begin
                if (cnt_q == act_q - RATIO_W'(1)) begin
                    cnt_n = '0;
                    if (ratio_vld) act_n = ratio_in;
                end else begin
                    cnt_n = cnt_q + RATIO_W'(1);
                end
            end
            default: st_n = GEN_IDLE;
        endcase
        hi_n    = act_n >> 1;
        q_pos_n = (st_n == GEN_RUN) && (cnt_n < hi_n);
    end

    // rising-edge outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            act_q   <= '0;
            q_pos_q <= 1'b0;
            odd_q   <= 1'b0;
        end else begin
            cnt_q   <= cnt_n;
            act_q   <= act_n;
            q_pos_q <= q_pos_n;
            odd_q   <= act_n[0];
        end
    end

    // falling-edge copy stretches odd high phases by half a cycle
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q_neg_q <= 1'b0;
        else        q_neg_q <= q_pos_q;
    end

    assign link_clk = odd_q ? (q_pos_q | q_neg_q) : q_pos_q;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GEN_RUN) |-> (cnt_q < act_q)); // R5
    AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == GEN_RUN) && $past(st_q == GEN_RUN) && (act_q != $past(act_q))) |-> (cnt_q == '0)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GEN_IDLE) |-> !link_clk); // R9
    AST_RUN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GEN_RUN) |-> (act_q >= RATIO_W'(MIN_RATIO))); // R3
endmodule

// File: rtl/blf_link_divider.sv
module blf_link_divider #(
    parameter int CNT_W   = 12,
    parameter int RATIO_W = CNT_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   trcal_cnt,
    input  logic               dr_hi,
    output logic [RATIO_W-1:0] ratio,
    output logic               ready,
    output logic               clamped,
    output logic               link_clk
);
    blf_ratio_calc #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) calc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .trcal_cnt (trcal_cnt),
        .dr_hi     (dr_hi),
        .ratio     (ratio),
        .ready     (ready),
        .clamped   (clamped)
    );

    blf_clk_gen #(.RATIO_W(RATIO_W)) gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_in  (ratio),
        .ratio_vld (ready),
        .link_clk  (link_clk)
    );
endmodule

// File: tb/blf_link_divider_tb_top.sv
module blf_link_divider_tb_top;
    localparam int CNT_W   = 12;
    localparam int RATIO_W = CNT_W - 2;
    localparam int NVEC    = 12;
    localparam real TCLK   = 4.0;

    // trcal count, selector, expected ratio, expected clamp flag
    localparam int V_N  [NVEC] = '{100, 99, 31, 16, 27, 100, 64, 73, 72, 40, 1000, 4095};
    localparam int V_DR [NVEC] = '{0,   0,  0,  0,  0,  1,   1,  1,  1,  1,  1,    0};
    localparam int V_R  [NVEC] = '{13,  12, 4,  3,  3,  5,   3,  4,  3,  3,  47,   512};
    localparam int V_C  [NVEC] = '{0,   0,  0,  1,  0,  0,   0,  0,  0,  1,  0,    0};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [CNT_W-1:0]   trcal_cnt = '0;
    logic               dr_hi = 1'b0;
    logic [RATIO_W-1:0] ratio;
    logic               ready;
    logic               clamped;
    logic               link_clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    blf_link_divider #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .trcal_cnt(trcal_cnt),
        .dr_hi(dr_hi), .ratio(ratio), .ready(ready), .clamped(clamped),
        .link_clk(link_clk)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_calc(input int n, input int dr);
        @(negedge clk);
        trcal_cnt = CNT_W'(n);
        dr_hi     = dr[0];
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b0, "R4 ready low after start", int'(ready), 0);
        @(negedge clk);
        @(negedge clk);
        check(ready == 1'b1, "R4 ready after two edges", int'(ready), 1);
    endtask

    task automatic measure(input int exp_ratio);
        real t0, t1, t2;
        @(posedge link_clk); t0 = $realtime;
        @(negedge link_clk); t1 = $realtime;
        @(posedge link_clk); t2 = $realtime;
        check((t2 - t0) == exp_ratio * TCLK, "R5 period", int'(t2 - t0), int'(exp_ratio * TCLK));
        check(((t1 - t0) * 2.0) == (t2 - t0), "R6 high time x2", int'((t1 - t0) * 2.0), int'(t2 - t0));
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen_new;
        bit ok7;
        real tp, tn, tr;
        // R8: reset state
        #1;
        check(ready == 1'b0, "R8 ready", int'(ready), 0);
        check(ratio == '0, "R8 ratio", int'(ratio), 0);
        check(clamped == 1'b0, "R8 clamped", int'(clamped), 0);
        check(link_clk == 1'b0, "R8 link_clk", int'(link_clk), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: quiet until the first ratio
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(link_clk == 1'b0, "R9 idle low", int'(link_clk), 0);
            #1;
            check(link_clk == 1'b0, "R9 idle low", int'(link_clk), 0);
        end

        // vector table: R1 (dr=0), R2 (dr=1), R3 clamp
        for (int v = 0; v < NVEC; v++) begin
            run_calc(V_N[v], V_DR[v]);
            check(int'(ratio) == V_R[v], (V_DR[v] != 0) ? "R2 ratio" : "R1 ratio", int'(ratio), V_R[v]);
            check(int'(clamped) == V_C[v], "R3 clamp flag", int'(clamped), V_C[v]);
            measure(V_R[v]);
        end

        // R7: change ratio 5 -> 4 mid-period, no runt or stretched period
        run_calc(100, 1);
        measure(5);
        repeat (7) @(negedge clk);
        @(negedge clk);
        trcal_cnt = CNT_W'(31);
        dr_hi     = 1'b0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen_new = 0;
        @(posedge link_clk); tp = $realtime;
        for (int k = 0; k < 8; k++) begin
            @(negedge link_clk); tn = $realtime;
            @(posedge link_clk); tr = $realtime;
            ok7 = ((tr - tp) == 5 * TCLK && !seen_new) || ((tr - tp) == 4 * TCLK);
            check(ok7, "R7 period old or new", int'(tr - tp), seen_new ? 16 : 20);
            check(((tn - tp) * 2.0) == (tr - tp), "R7 R6 no runt pulse", int'((tn - tp) * 2.0), int'(tr - tp));
            if ((tr - tp) == 4 * TCLK) seen_new = 1;
            tp = tr;
        end
        check(seen_new, "R7 new ratio adopted", int'(seen_new), 1);

        // R3: smallest odd ratio after clamp keeps 50% duty (R6)
        run_calc(8, 0);
        check(ratio == RATIO_W'(3) && clamped, "R3 clamp from 1", int'(ratio), 3);
        measure(3);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule